// File: doc/BRIEF.md
# Paged DMA Address Generator

This block produces the physical memory address for every transfer beat of a DMA engine that feeds a disk-side storage controller. Software describes a buffer that is contiguous in virtual space as a table of page frames, one 16-bit frame number per 4096-byte page, and sets a start register with an offset into the first page and a direction bit. A start command then walks the buffer. Each beat accepted on the data side moves the in-page offset by one. When the offset runs past the end of a page, the walk continues at offset zero of the next table entry.

The register port is a plain single-cycle write and read interface. Read data appears on the cycle after the read strobe. Apart from the start register and the page table, the port decodes a command that starts a walk and a flush command that abandons one. It also decodes two read-triggered strobes that drive a reset line to the attached controller. When a walk runs off the end of the table, it stops and raises an overrun flag rather than wrapping round.

Top module: `pdma_addr_gen`

## Requirements
- R1: The page table holds PAGE_CNT entries of PAGE_W bits. Entry n is written and read at register address 0x800 + 4·n. A read returns the entry zero-extended on reg_rdata in the cycle after the read strobe.
- R2: The start register sits at address 0x000. Its bits 11:0 are the first-page offset and bit 15 is the direction. Bits 14:12, and every bit above 15, are dropped on write and read back as zero.
- R3: Any write to address 0x008 starts a walk. busy_o rises and ready_o stays low for exactly one cycle, then ready_o rises.
- R4: While ready_o is high, addr_o equals {table entry of the current page, 12-bit offset}. The first page uses the start offset. dir_o holds bit 15 of the start register as captured at the start: 1 means controller-to-memory and 0 means memory-to-controller.
- R5: A beat is accepted when beat_i and ready_o are both high. Inside a page, each accepted beat raises the offset by one with no gap in ready_o.
- R6: A beat accepted at offset 0xFFF moves to offset 0x000 of the next table entry. ready_o is low for exactly one cycle while that entry is fetched.
- R7: A beat accepted at offset 0xFFF of the last entry (PAGE_CNT-1) ends the walk. busy_o falls and overrun_o rises. overrun_o stays high until the next start or flush.
- R8: Writing 0 to address 0x00C flushes the walk: busy_o, ready_o and overrun_o go low. A nonzero write there has no effect. A flush wins over a beat accepted in the same cycle.
- R9: A read of address 0x010 drives dev_rst_o high, and a read of address 0x014 drives it low. Both reads return 0.
- R10: After reset, busy_o, ready_o, overrun_o and dev_rst_o are low, and the start register reads 0.
- R11: beat_i has no effect while ready_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| beat_i | input | 1 | Data side offers a transfer beat |
| ready_o | output | 1 | Address valid; a beat is taken this cycle |
| busy_o | output | 1 | Walk in progress |
| addr_o | output | PAGE_W+12 | Physical address of the current beat |
| dir_o | output | 1 | 1 = controller to memory |
| overrun_o | output | 1 | Walk ran past the last table entry |
| dev_rst_o | output | 1 | Reset line to the attached controller |

## Verification
A flush write and an accepted beat can land on the same clock edge. The bench provokes this by holding beat_i high while ready_o is high and issuing the zero write to the flush address in that same cycle. It judges the result by busy_o and ready_o falling on the following cycle, and by a fresh start that reloads offset and page index instead of resuming the old walk. A nonzero flush write during a walk is checked to leave the address unchanged.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int unsigned REG_AW = 12;
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned DIR_BIT = 15;

  localparam logic [REG_AW-1:0] A_LOW     = 12'h000;
  localparam logic [REG_AW-1:0] A_START   = 12'h008;
  localparam logic [REG_AW-1:0] A_FLUSH   = 12'h00C;
  localparam logic [REG_AW-1:0] A_RST_SET = 12'h010;
  localparam logic [REG_AW-1:0] A_RST_CLR = 12'h014;
  localparam logic [REG_AW-1:0] A_PG_BASE = 12'h800;

  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_RUN} walk_st_e;
  typedef enum logic [1:0] {RS_NONE, RS_LOW, RS_PAGE} rsel_e;
endpackage

// File: rtl/pdma_page_ram.sv
module pdma_page_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_a,
  output logic [DW-1:0] rq_a,
  input  logic [IW-1:0] ra_b,
  output logic [DW-1:0] rq_b
);
  logic [DW-1:0] mem [DEPTH];

  // Read-first synchronous ports, no reset: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rq_a <= mem[ra_a];
    rq_b <= mem[ra_b];
  end
endmodule

// File: rtl/pdma_reg_if.sv
module pdma_reg_if
  import pdma_pkg::*;
#(
  parameter int unsigned PAGE_CNT = 256,
  parameter int unsigned PAGE_W   = 16,
  localparam int unsigned IW      = $clog2(PAGE_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              pg_we,
  output logic [IW-1:0]     pg_idx,
  output logic [PAGE_W-1:0] pg_wdata,
  input  logic [PAGE_W-1:0] pg_rq,
  output logic              start_o,
  output logic              flush_o,
  output logic [OFS_W-1:0]  low_ofs,
  output logic              low_dir,
  output logic              dev_rst_o
);
  logic [REG_AW-1:0] pg_off;
  logic [REG_AW-3:0] pg_n;
  logic              pg_hit;
  rsel_e             rsel_q;

  assign pg_off   = reg_addr - A_PG_BASE;
  assign pg_n     = pg_off[REG_AW-1:2];
  assign pg_hit   = (reg_addr >= A_PG_BASE) && (pg_off[1:0] == 2'b00)
                    && (int'(pg_n) < int'(PAGE_CNT));
  assign pg_idx   = pg_n[IW-1:0];
  assign pg_we    = reg_wr && pg_hit;
  assign pg_wdata = reg_wdata[PAGE_W-1:0];
  assign start_o  = reg_wr && (reg_addr == A_START);
  assign flush_o  = reg_wr && (reg_addr == A_FLUSH) && (reg_wdata == 32'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_ofs   <= '0;
      low_dir   <= 1'b0;
      dev_rst_o <= 1'b0;
      rsel_q    <= RS_NONE;
    end else begin
      if (reg_wr && reg_addr == A_LOW) begin
        low_ofs <= reg_wdata[OFS_W-1:0];
        low_dir <= reg_wdata[DIR_BIT];
      end
      if (reg_rd && reg_addr == A_RST_SET) dev_rst_o <= 1'b1;
      if (reg_rd && reg_addr == A_RST_CLR) dev_rst_o <= 1'b0;
      if (!reg_rd)                      rsel_q <= RS_NONE;
      else if (reg_addr == A_LOW)       rsel_q <= RS_LOW;
      else if (pg_hit)                  rsel_q <= RS_PAGE;
      else                              rsel_q <= RS_NONE;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (rsel_q)
      RS_LOW: begin
        reg_rdata[OFS_W-1:0] = low_ofs;
        reg_rdata[DIR_BIT]   = low_dir;
      end
      RS_PAGE: reg_rdata[PAGE_W-1:0] = pg_rq;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pdma_walker.sv
module pdma_walker
  import pdma_pkg::*;
#(
  parameter int unsigned PAGE_CNT = 256,
  parameter int unsigned PAGE_W   = 16,
  localparam int unsigned IW      = $clog2(PAGE_CNT)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    flush_i,
  input  logic [OFS_W-1:0]        low_ofs,
  input  logic                    low_dir,
  input  logic                    beat_i,
  input  logic [PAGE_W-1:0]       pg_q,
  output logic [IW-1:0]           idx_o,
  output logic                    ready_o,
  output logic                    busy_o,
  output logic                    overrun_o,
  output logic                    dir_o,
  output logic [PAGE_W+OFS_W-1:0] addr_o
);
  walk_st_e         st_q;
  logic [IW-1:0]    idx_q;
  logic [OFS_W-1:0] ofs_q;
  logic             take, at_end, last_pg;

  assign take    = (st_q == W_RUN) && beat_i;
  assign at_end  = &ofs_q;
  assign last_pg = (idx_q == IW'(PAGE_CNT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= W_IDLE;
      idx_q     <= '0;
      ofs_q     <= '0;
      dir_o     <= 1'b0;
      overrun_o <= 1'b0;
    end else if (flush_i) begin
      st_q      <= W_IDLE;
      idx_q     <= '0;
      ofs_q     <= '0;
      overrun_o <= 1'b0;
    end else if (start_i) begin
      st_q      <= W_FETCH;
      idx_q     <= '0;
      ofs_q     <= low_ofs;
      dir_o     <= low_dir;
      overrun_o <= 1'b0;
    end else begin
      case (st_q)
        W_FETCH: st_q <= W_RUN;
        W_RUN: if (take) begin
          ofs_q <= ofs_q + OFS_W'(1);
          if (at_end) begin
            if (last_pg) begin
              st_q      <= W_IDLE;
              overrun_o <= 1'b1;
            end else begin
              idx_q <= idx_q + IW'(1);
              st_q  <= W_FETCH;
            end
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign ready_o = (st_q == W_RUN);
  assign busy_o  = (st_q != W_IDLE);
  assign addr_o  = {pg_q, ofs_q};
endmodule

// File: rtl/pdma_addr_gen.sv
module pdma_addr_gen
  import pdma_pkg::*;
#(
  parameter int unsigned PAGE_CNT = 256,
  parameter int unsigned PAGE_W   = 16,
  localparam int unsigned IW      = $clog2(PAGE_CNT),
  localparam int unsigned AW      = PAGE_W + OFS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [11:0]   reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          beat_i,
  output logic          ready_o,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic          dir_o,
  output logic          overrun_o,
  output logic          dev_rst_o
);
  logic              pg_we, start_s, flush_s, low_dir;
  logic [IW-1:0]     reg_idx, walk_idx;
  logic [PAGE_W-1:0] pg_wdata, pg_walk_q, pg_reg_q;
  logic [OFS_W-1:0]  low_ofs;

  pdma_page_ram #(.DEPTH(PAGE_CNT), .DW(PAGE_W)) u_ram (
    .clk(clk), .we(pg_we), .waddr(reg_idx), .wdata(pg_wdata),
    .ra_a(walk_idx), .rq_a(pg_walk_q), .ra_b(reg_idx), .rq_b(pg_reg_q)
  );

  pdma_reg_if #(.PAGE_CNT(PAGE_CNT), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pg_we(pg_we), .pg_idx(reg_idx), .pg_wdata(pg_wdata), .pg_rq(pg_reg_q),
    .start_o(start_s), .flush_o(flush_s), .low_ofs(low_ofs),
    .low_dir(low_dir), .dev_rst_o(dev_rst_o)
  );

  pdma_walker #(.PAGE_CNT(PAGE_CNT), .PAGE_W(PAGE_W)) u_walk (
    .clk(clk), .rst(rst), .start_i(start_s), .flush_i(flush_s),
    .low_ofs(low_ofs), .low_dir(low_dir), .beat_i(beat_i),
    .pg_q(pg_walk_q), .idx_o(walk_idx), .ready_o(ready_o),
    .busy_o(busy_o), .overrun_o(overrun_o), .dir_o(dir_o), .addr_o(addr_o)
  );
endmodule

// File: rtl/pdma_addr_gen_chk.sv
module pdma_addr_gen_chk
  import pdma_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [11:0] reg_addr,
  input logic        reg_rd,
  input logic [31:0] reg_rdata,
  input logic        beat_i,
  input logic        ready_o,
  input logic        busy_o,
  input logic [11:0] ofs_i,
  input logic        overrun_o,
  input logic        dev_rst_o,
  input logic        start_s,
  input logic        flush_s
);
  // R2
  low_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_LOW) |=> (reg_rdata[31:16] == 16'd0 && reg_rdata[14:12] == 3'd0));

  // R3
  start_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (start_s && !flush_s) |=> (busy_o && !ready_o));

  // R5
  ofs_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o && beat_i && !start_s && !flush_s && ofs_i != 12'hFFF)
    |=> (ready_o && ofs_i == $past(ofs_i) + 12'd1));

  // R6
  wrap_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o && beat_i && !start_s && !flush_s && ofs_i == 12'hFFF)
    |=> (!ready_o && ofs_i == 12'd0));

  // R7
  overrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !start_s && !flush_s) |=> (overrun_o && !busy_o));

  // R8
  flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
    flush_s |=> (!busy_o && !ready_o && !overrun_o));

  // R9
  rst_set_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_RST_SET) |=> dev_rst_o);

  // R9
  rst_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_RST_CLR) |=> !dev_rst_o);
endmodule

bind pdma_addr_gen pdma_addr_gen_chk u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .beat_i(beat_i), .ready_o(ready_o),
  .busy_o(busy_o), .ofs_i(addr_o[11:0]), .overrun_o(overrun_o),
  .dev_rst_o(dev_rst_o), .start_s(start_s), .flush_s(flush_s)
);

// File: tb/pdma_addr_gen_tb.sv
`timescale 1ns/1ps
module pdma_addr_gen_tb;
  localparam int NPG = 4;
  localparam int PW  = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, beat_i = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ready_o, busy_o, dir_o, overrun_o, dev_rst_o;
  logic [PW+11:0] addr_o;

  always #2 clk = ~clk;

  pdma_addr_gen #(.PAGE_CNT(NPG), .PAGE_W(PW)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .beat_i(beat_i), .ready_o(ready_o), .busy_o(busy_o), .addr_o(addr_o),
    .dir_o(dir_o), .overrun_o(overrun_o), .dev_rst_o(dev_rst_o)
  );

  int checks = 0, fails = 0;
  logic [PW-1:0]  pg [NPG];
  logic [PW+11:0] expq [$];
  bit  mon_on = 0, bubble = 0;
  int  popped = 0;
  int  m_idx;
  logic [11:0] m_ofs;
  logic [31:0] rd;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // driver: push expected addresses, then offer beats until all are taken
  task automatic run_beats(input int n);
    for (int k = 0; k < n; k++) begin
      expq.push_back({(m_idx < NPG) ? pg[m_idx] : 16'h0, m_ofs});
      if (m_ofs == 12'hFFF) m_idx++;
      m_ofs = m_ofs + 12'd1;
    end
    popped = 0; mon_on = 1; beat_i = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (popped >= n) break;
    end
    beat_i = 1'b0; mon_on = 0;
  endtask

  // monitor: at each falling edge, compare the address offered to an accepted beat
  always @(negedge clk) begin
    if (mon_on) begin
      if (bubble) begin
        chk(!ready_o, "R6 bubble after page end", ready_o, 0);
        bubble = 0;
      end else if (beat_i && ready_o) begin
        if (expq.size() == 0) chk(0, "R5 unexpected beat", addr_o, 0);
        else begin
          logic [PW+11:0] e;
          e = expq.pop_front();
          chk(addr_o == e, "R4 R5 beat address", addr_o, e);
          if (e[11:0] == 12'hFFF) bubble = 1;
        end
        popped++;
      end
    end
  end

  task automatic do_start(input logic [11:0] ofs);
    wr(12'h008, 32'h0);
    chk(busy_o && !ready_o, "R3 fetch cycle", {busy_o, ready_o}, 2'b10);
    @(posedge clk); #1;
    chk(ready_o, "R3 ready after fetch", ready_o, 1);
    m_idx = 0; m_ofs = ofs;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPG; i++) pg[i] = 16'hA000 + 16'(i * 16'h0135);
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;

    // R10 reset state
    chk({busy_o, ready_o, overrun_o, dev_rst_o} == 4'b0, "R10 outputs after reset",
        {busy_o, ready_o, overrun_o, dev_rst_o}, 0);
    rdreg(12'h000, rd);
    chk(rd == 0, "R10 start register after reset", rd, 0);

    // R1 page table
    for (int i = 0; i < NPG; i++) wr(12'h800 + 12'(4 * i), {16'hDEAD, pg[i]});
    rdreg(12'h808, rd);
    chk(rd == {16'h0, pg[2]}, "R1 page entry 2 readback", rd, {16'h0, pg[2]});
    rdreg(12'h800, rd);
    chk(rd == {16'h0, pg[0]}, "R1 page entry 0 readback", rd, {16'h0, pg[0]});

    // R2 start register field masking
    wr(12'h000, 32'hFFFF_F123);
    rdreg(12'h000, rd);
    chk(rd == 32'h0000_8123, "R2 start register readback", rd, 32'h8123);

    // R11 beats before start are ignored
    beat_i = 1'b1;
    repeat (5) begin
      @(posedge clk); #1;
      chk(!ready_o && !busy_o, "R11 idle with beat", {busy_o, ready_o}, 0);
    end
    beat_i = 1'b0;
    do_start(12'h123);
    chk(addr_o == {pg[0], 12'h123}, "R4 first address", addr_o, {pg[0], 12'h123});
    chk(dir_o == 1'b1, "R4 direction set", dir_o, 1);
    run_beats(7);

    // R5 R6 crossing a page end, direction clear
    wr(12'h000, 32'h0000_0FF8);
    do_start(12'hFF8);
    chk(dir_o == 1'b0, "R4 direction clear", dir_o, 0);
    run_beats(20);

    // R8 nonzero flush ignored
    wr(12'h00C, 32'h1);
    chk(busy_o && ready_o && addr_o == {pg[1], 12'h00C}, "R8 nonzero flush ignored",
        addr_o, {pg[1], 12'h00C});
    // R8 flush and beat in the same cycle
    @(posedge clk); #1;
    reg_addr = 12'h00C; reg_wdata = 32'h0; reg_wr = 1'b1; beat_i = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; beat_i = 1'b0;
    chk(!busy_o && !ready_o, "R8 flush beats a beat", {busy_o, ready_o}, 0);
    do_start(12'hFF8);
    chk(addr_o == {pg[0], 12'hFF8}, "R8 restart after flush", addr_o, {pg[0], 12'hFF8});

    // R7 overrun at the end of the table
    wr(12'h000, 32'h0000_0FF0);
    do_start(12'hFF0);
    run_beats(16 + (NPG - 1) * 4096);
    chk(overrun_o && !busy_o, "R7 overrun raised", {overrun_o, busy_o}, 2'b10);
    beat_i = 1'b1;
    repeat (3) @(posedge clk);
    #1; beat_i = 1'b0;
    chk(overrun_o && !ready_o, "R7 overrun held, R11 beats ignored", {overrun_o, ready_o}, 2'b10);
    wr(12'h00C, 32'h0);
    chk(!overrun_o, "R8 flush clears overrun", overrun_o, 0);

    // R9 controller reset strobes
    rdreg(12'h010, rd);
    chk(dev_rst_o && rd == 0, "R9 reset set by read", {dev_rst_o, rd}, {1'b1, 32'h0});
    rdreg(12'h014, rd);
    chk(!dev_rst_o && rd == 0, "R9 reset cleared by read", {dev_rst_o, rd}, 0);

    chk(expq.size() == 0, "R5 scoreboard drained", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule